// File: doc/BRIEF.md
# Dual I/O Window Decoder

This block sits between a host I/O bus and a removable card slot and decides, one host access at a time, whether the address belongs to one of two programmable I/O windows. Each window is bounded by an inclusive 16-bit start address and an inclusive 16-bit stop address. On a hit the block passes the address through to the card unchanged and raises the qualifiers of the winning window: a 16-bit transfer indication, a zero-wait-state request and an extra-wait-state request.

Software programs the block through a byte-wide port. One shared enable byte holds a bit per I/O window next to the enable bits of the memory windows, which are only stored here and handed on to the memory decoder. One shared control byte holds four flag bits per I/O window, one nibble each. Because of this packing, the block offers two nibble-wide aliases of that byte, so one window's flags can be changed without disturbing the other's. Software that retires a window is expected to clear its enable bit first and zero its bounds afterwards. The enable bit alone gates the hit, so the window goes quiet as soon as that bit is cleared.

Top module: `iowin_decoder`

## Requirements
- R1: After a synchronous reset, every programmable byte reads 0, `mem_win_en` is 0 and all decode outputs (`io_hit`, `io_win`, `io_card_addr`, `io_is16`, `io_zws`, `io_ws`) are 0.
- R2: The register map has these offsets. 0 is enable. 1 is control. 2 and 3 are the window 0 start address, low byte then high byte, and 4 and 5 are its stop address, low then high. 6 to 9 hold the same four bytes for window 1. A write with `prog_we` high lands at the rising edge. `prog_rdata` shows the byte at `prog_addr` one cycle later. Offsets 12 to 15 ignore writes and read 0.
- R3: Control bits [3:0] are window 0 flags and [7:4] are window 1 flags. A write to offset 10 replaces only bits [3:0] and a write to offset 11 replaces only bits [7:4], each with `prog_wdata[3:0]`. Reading offset 10 or 11 returns that window's nibble zero-extended.
- R4: A window hits when `host_valid` is high, its enable bit is set, and start <= `host_addr` <= stop. Both bounds are inclusive, and start equal to stop makes a one-address window.
- R5: Enable bit 0 gates window 0 and bit 1 gates window 1. A window whose bit is clear never hits, whatever its bounds.
- R6: When both windows hit, window 0 wins and `io_win` is 0.
- R7: Flag bit 0 of a nibble selects 16-bit data and bit 1 selects the card as chip-select-16 source. On a hit, if bit 1 is set, `io_is16` equals `card_iois16` sampled with the address. Otherwise it equals bit 0.
- R8: On a hit, `io_zws` is flag bit 2 and `io_ws` is flag bit 3 of the winning window. On a miss, `io_is16`, `io_zws` and `io_ws` are all 0.
- R9: On a hit, `io_card_addr` equals `host_addr` untranslated. On a miss it is 0. With `host_valid` low, the block never hits.
- R10: All decode outputs are registered and reflect the inputs sampled at the previous rising edge.
- R11: `mem_win_en` equals enable bits [7:2] and has no effect on I/O decoding.
- R12: A window whose start address is above its stop address never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Programming write strobe |
| prog_addr | input | 4 | Programming byte offset |
| prog_wdata | input | 8 | Programming write data |
| prog_rdata | output | 8 | Registered programming read data |
| host_valid | input | 1 | Host I/O access present |
| host_addr | input | 16 | Host I/O address |
| card_iois16 | input | 1 | Card's 16-bit I/O indication |
| io_hit | output | 1 | Access falls in an enabled window |
| io_win | output | 1 | Index of the winning window |
| io_card_addr | output | 16 | Address presented to the card |
| io_is16 | output | 1 | 16-bit transfer indication |
| io_zws | output | 1 | Zero-wait-state request |
| io_ws | output | 1 | Extra-wait-state request |
| mem_win_en | output | 6 | Memory window enables for the neighbouring decoder |

## Verification
On every cycle, the assertions check that a reported hit came from a valid access inside the bounds of an enabled window. They also check that window 1 is only reported when window 0 could not have matched, that the address passes through untouched, that a miss leaves every qualifier low, and that unmapped offsets read 0. What the assertions cannot show is which flag drives each qualifier, how the two nibble aliases preserve the neighbouring nibble, and what happens to empty or single-address windows. Those are only visible through the bench's programmed scenarios.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int NUM_WIN  = 2;
  localparam int FLAG_W   = 4;
  localparam int WIN_IW   = 1;
  localparam int EN_W     = 8;
  localparam int MEM_EN_W = EN_W - NUM_WIN;
  // flag bit positions inside a window nibble
  localparam int FL_DATA16 = 0;
  localparam int FL_CS16   = 1;
  localparam int FL_ZWS    = 2;
  localparam int FL_WS     = 3;
  // fixed offsets
  localparam int OFS_EN    = 0;
  localparam int OFS_CTRL  = 1;
  localparam int OFS_WBASE = 2;
endpackage

// File: rtl/iowin_regs.sv
module iowin_regs
  import iowin_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PROG_AW = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             prog_we,
  input  logic [PROG_AW-1:0]               prog_addr,
  input  logic [7:0]                       prog_wdata,
  output logic [7:0]                       prog_rdata,
  output logic [NUM_WIN-1:0]               win_en,
  output logic [NUM_WIN-1:0][FLAG_W-1:0]   win_flags,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_start,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_stop,
  output logic [MEM_EN_W-1:0]              mem_en
);
  localparam int NB       = ADDR_W / 8;
  localparam int WSPAN    = 2 * NB;
  localparam int OFS_NIB  = OFS_WBASE + WSPAN * NUM_WIN;

  logic [EN_W-1:0] en_q;
  logic [7:0]      ctrl_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] start_q, stop_q;
  logic [7:0]      rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      ctrl_q  <= '0;
      start_q <= '0;
      stop_q  <= '0;
    end else if (prog_we) begin
      if (prog_addr == PROG_AW'(OFS_EN))   en_q   <= prog_wdata;
      if (prog_addr == PROG_AW'(OFS_CTRL)) ctrl_q <= prog_wdata;
      for (int w = 0; w < NUM_WIN; w++) begin
        for (int b = 0; b < NB; b++) begin
          if (prog_addr == PROG_AW'(OFS_WBASE + WSPAN*w + b))
            start_q[w][8*b +: 8] <= prog_wdata;
          if (prog_addr == PROG_AW'(OFS_WBASE + WSPAN*w + NB + b))
            stop_q[w][8*b +: 8] <= prog_wdata;
        end
        if (prog_addr == PROG_AW'(OFS_NIB + w))
          ctrl_q[FLAG_W*w +: FLAG_W] <= prog_wdata[FLAG_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (prog_addr == PROG_AW'(OFS_EN))   rd_mux = en_q;
    if (prog_addr == PROG_AW'(OFS_CTRL)) rd_mux = ctrl_q;
    for (int w = 0; w < NUM_WIN; w++) begin
      for (int b = 0; b < NB; b++) begin
        if (prog_addr == PROG_AW'(OFS_WBASE + WSPAN*w + b))
          rd_mux = start_q[w][8*b +: 8];
        if (prog_addr == PROG_AW'(OFS_WBASE + WSPAN*w + NB + b))
          rd_mux = stop_q[w][8*b +: 8];
      end
      if (prog_addr == PROG_AW'(OFS_NIB + w))
        rd_mux = {{(8-FLAG_W){1'b0}}, ctrl_q[FLAG_W*w +: FLAG_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prog_rdata <= '0;
    else     prog_rdata <= rd_mux;
  end

  assign win_en    = en_q[NUM_WIN-1:0];
  assign mem_en    = en_q[EN_W-1:NUM_WIN];
  assign win_start = start_q;
  assign win_stop  = stop_q;
  always_comb
    for (int w = 0; w < NUM_WIN; w++) win_flags[w] = ctrl_q[FLAG_W*w +: FLAG_W];
endmodule

// File: rtl/iowin_cmp.sv
module iowin_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/iowin_sel.sv
module iowin_sel
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           valid,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           iois16,
  input  logic [NUM_WIN-1:0]             hit,
  input  logic [NUM_WIN-1:0][FLAG_W-1:0] flags,
  output logic                           o_hit,
  output logic [WIN_IW-1:0]              o_win,
  output logic [ADDR_W-1:0]              o_addr,
  output logic                           o_is16,
  output logic                           o_zws,
  output logic                           o_ws
);
  always_ff @(posedge clk) begin
    if (rst) begin
      o_hit  <= 1'b0;
      o_win  <= '0;
      o_addr <= '0;
      o_is16 <= 1'b0;
      o_zws  <= 1'b0;
      o_ws   <= 1'b0;
    end else begin
      o_hit  <= 1'b0;
      o_win  <= '0;
      o_addr <= '0;
      o_is16 <= 1'b0;
      o_zws  <= 1'b0;
      o_ws   <= 1'b0;
      // descending walk: the lowest index is assigned last and wins
      for (int w = NUM_WIN-1; w >= 0; w--) begin
        if (valid && hit[w]) begin
          o_hit  <= 1'b1;
          o_win  <= WIN_IW'(w);
          o_addr <= addr;
          o_is16 <= flags[w][FL_CS16] ? iois16 : flags[w][FL_DATA16];
          o_zws  <= flags[w][FL_ZWS];
          o_ws   <= flags[w][FL_WS];
        end
      end
    end
  end
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PROG_AW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prog_we,
  input  logic [PROG_AW-1:0]  prog_addr,
  input  logic [7:0]          prog_wdata,
  output logic [7:0]          prog_rdata,
  input  logic                host_valid,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                card_iois16,
  output logic                io_hit,
  output logic [WIN_IW-1:0]   io_win,
  output logic [ADDR_W-1:0]   io_card_addr,
  output logic                io_is16,
  output logic                io_zws,
  output logic                io_ws,
  output logic [MEM_EN_W-1:0] mem_win_en
);
  logic [NUM_WIN-1:0]             win_en;
  logic [NUM_WIN-1:0][FLAG_W-1:0] win_flags;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_start, win_stop;
  logic [NUM_WIN-1:0]             win_hit;

  iowin_regs #(.ADDR_W(ADDR_W), .PROG_AW(PROG_AW)) u_regs (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_wdata(prog_wdata), .prog_rdata(prog_rdata), .win_en(win_en),
    .win_flags(win_flags), .win_start(win_start), .win_stop(win_stop),
    .mem_en(mem_win_en)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    iowin_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .en(win_en[w]), .lo(win_start[w]), .hi(win_stop[w]),
      .addr(host_addr), .hit(win_hit[w])
    );
  end

  iowin_sel #(.ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst(rst), .valid(host_valid), .addr(host_addr),
    .iois16(card_iois16), .hit(win_hit), .flags(win_flags),
    .o_hit(io_hit), .o_win(io_win), .o_addr(io_card_addr),
    .o_is16(io_is16), .o_zws(io_zws), .o_ws(io_ws)
  );
endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk
  import iowin_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PROG_AW = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic [PROG_AW-1:0]             prog_addr,
  input logic [7:0]                     prog_rdata,
  input logic                           host_valid,
  input logic [ADDR_W-1:0]              host_addr,
  input logic                           io_hit,
  input logic [WIN_IW-1:0]              io_win,
  input logic [ADDR_W-1:0]              io_card_addr,
  input logic                           io_is16,
  input logic                           io_zws,
  input logic                           io_ws,
  input logic [NUM_WIN-1:0]             win_en,
  input logic [NUM_WIN-1:0][ADDR_W-1:0] win_start,
  input logic [NUM_WIN-1:0][ADDR_W-1:0] win_stop
);
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !io_hit |-> (io_card_addr == '0 && !io_is16 && !io_zws && !io_ws)); // R8
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    io_hit |-> $past(host_valid)); // R9
  AST_ADDR_THROUGH: assert property (@(posedge clk) disable iff (rst)
    io_hit |-> io_card_addr == $past(host_addr)); // R9
  AST_W0_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (io_hit && io_win == 1'b0) |-> ($past(win_en[0]) &&
      $past(host_addr) >= $past(win_start[0]) && $past(host_addr) <= $past(win_stop[0]))); // R4
  AST_W1_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (io_hit && io_win == 1'b1) |-> ($past(win_en[1]) &&
      $past(host_addr) >= $past(win_start[1]) && $past(host_addr) <= $past(win_stop[1]))); // R5
  AST_W0_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (io_hit && io_win == 1'b1) |-> !($past(win_en[0]) &&
      $past(host_addr) >= $past(win_start[0]) && $past(host_addr) <= $past(win_stop[0]))); // R6
  AST_HOLE_READ: assert property (@(posedge clk) disable iff (rst)
    ($past(prog_addr) > PROG_AW'(11)) |-> prog_rdata == 8'h00); // R2
endmodule

bind iowin_decoder iowin_decoder_chk #(.ADDR_W(ADDR_W), .PROG_AW(PROG_AW)) u_chk (
  .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_rdata(prog_rdata),
  .host_valid(host_valid), .host_addr(host_addr), .io_hit(io_hit),
  .io_win(io_win), .io_card_addr(io_card_addr), .io_is16(io_is16),
  .io_zws(io_zws), .io_ws(io_ws), .win_en(win_en),
  .win_start(win_start), .win_stop(win_stop)
);

// File: tb/iowin_decoder_tb.sv
module iowin_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [3:0]  prog_addr = '0;
  logic [7:0]  prog_wdata = '0;
  logic [7:0]  prog_rdata;
  logic        host_valid = 1'b0;
  logic [15:0] host_addr = '0;
  logic        card_iois16 = 1'b0;
  logic        io_hit, io_win, io_is16, io_zws, io_ws;
  logic [15:0] io_card_addr;
  logic [5:0]  mem_win_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iowin_decoder u_dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_wdata(prog_wdata), .prog_rdata(prog_rdata), .host_valid(host_valid),
    .host_addr(host_addr), .card_iois16(card_iois16), .io_hit(io_hit),
    .io_win(io_win), .io_card_addr(io_card_addr), .io_is16(io_is16),
    .io_zws(io_zws), .io_ws(io_ws), .mem_win_en(mem_win_en)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        valid;
    logic        iois;
    logic        hit;
    logic        win;
    logic        is16;
    logic        zws;
    logic        ws;
  } vec_t;

  // window 0: 0x0300..0x031F nibble 0x5 (data16, zws)
  // window 1: 0x0310..0x03FF nibble 0xA (card cs16 source, ws)
  localparam vec_t VECS [9] = '{
    '{16'h02FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h0300, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{16'h031F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // overlap, R6
    '{16'h0320, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{16'h0320, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'h03FF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{16'h0400, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h0310, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h0315, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = a; prog_wdata = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    prog_addr = a;
    @(negedge clk);
    d = prog_rdata;
  endtask

  task automatic look(input logic [15:0] a, input logic v, input logic i);
    @(negedge clk);
    host_addr = a; host_valid = v; card_iois16 = i;
    @(negedge clk);
  endtask

  task automatic set_win(input int w, input logic [15:0] lo, input logic [15:0] hi);
    wr(4'(2 + 4*w), lo[7:0]);
    wr(4'(3 + 4*w), lo[15:8]);
    wr(4'(4 + 4*w), hi[7:0]);
    wr(4'(5 + 4*w), hi[15:8]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 io_hit", io_hit, 0);
    chk("R1 io_card_addr", io_card_addr, 0);
    chk("R1 qualifiers", {io_win, io_is16, io_zws, io_ws}, 0);
    chk("R1 mem_win_en", mem_win_en, 0);
    rd(4'd1, d); chk("R1 ctrl", d, 8'h00);
    rd(4'd9, d); chk("R1 w1 stop hi", d, 8'h00);

    // programming, R2 and R11
    wr(4'd0, 8'hAB);
    set_win(0, 16'h0300, 16'h031F);
    set_win(1, 16'h0310, 16'h03FF);
    wr(4'd1, 8'hA5);
    rd(4'd1, d); chk("R2 ctrl readback", d, 8'hA5);
    rd(4'd3, d); chk("R2 w0 start hi", d, 8'h03);
    rd(4'd8, d); chk("R2 w1 stop lo", d, 8'hFF);
    chk("R11 mem_win_en", mem_win_en, 6'h2A);

    // R10 latency: output holds until the edge after the sample
    look(16'h0000, 1'b1, 1'b0);
    @(negedge clk);
    host_addr = 16'h0300; host_valid = 1'b1; card_iois16 = 1'b0;
    #2;
    chk("R10 before edge", io_hit, 0);
    @(negedge clk);
    chk("R10 after edge", io_hit, 1);

    // vector table: R4 R6 R7 R8 R9
    for (int k = 0; k < 9; k++) begin
      look(VECS[k].addr, VECS[k].valid, VECS[k].iois);
      chk($sformatf("R4 hit v%0d", k), io_hit, VECS[k].hit);
      chk($sformatf("R6 win v%0d", k), io_win, VECS[k].win);
      chk($sformatf("R7 is16 v%0d", k), io_is16, VECS[k].is16);
      chk($sformatf("R8 zws/ws v%0d", k), {io_zws, io_ws}, {VECS[k].zws, VECS[k].ws});
      chk($sformatf("R9 card addr v%0d", k), io_card_addr,
          VECS[k].hit ? VECS[k].addr : 16'h0000);
    end

    // R3 nibble aliases preserve the other nibble
    wr(4'd11, 8'hF3);
    rd(4'd1, d); chk("R3 w1 nibble write", d, 8'h35);
    wr(4'd10, 8'h0C);
    rd(4'd1, d); chk("R3 w0 nibble write", d, 8'h3C);
    rd(4'd10, d); chk("R3 w0 nibble read", d, 8'h0C);
    rd(4'd11, d); chk("R3 w1 nibble read", d, 8'h03);
    wr(4'd1, 8'hA5);

    // R2 unmapped offset ignored and reads 0
    wr(4'd12, 8'hFF);
    rd(4'd1, d); chk("R2 ctrl untouched", d, 8'hA5);
    rd(4'd0, d); chk("R2 enable untouched", d, 8'hAB);
    rd(4'd12, d); chk("R2 hole reads zero", d, 8'h00);

    // R5 enable gating
    wr(4'd0, 8'hAA);
    look(16'h0310, 1'b1, 1'b1);
    chk("R5 w0 off, overlap goes to w1", {io_hit, io_win}, 2'b11);
    look(16'h0300, 1'b1, 1'b1);
    chk("R5 w0 off miss", io_hit, 0);
    wr(4'd0, 8'hFC);
    look(16'h0350, 1'b1, 1'b1);
    chk("R5 both off miss", io_hit, 0);
    chk("R11 mem bits all set", mem_win_en, 6'h3F);

    // R12 empty window and R4 single-address window
    wr(4'd0, 8'h02);
    set_win(1, 16'h0500, 16'h04FF);
    look(16'h0500, 1'b1, 1'b0);
    chk("R12 start above stop low", io_hit, 0);
    look(16'h04FF, 1'b1, 1'b0);
    chk("R12 start above stop high", io_hit, 0);
    set_win(1, 16'h0500, 16'h0500);
    look(16'h0500, 1'b1, 1'b0);
    chk("R4 single address hit", {io_hit, io_win}, 2'b11);
    look(16'h0501, 1'b1, 1'b0);
    chk("R4 single address miss", io_hit, 0);

    finish_run();
  end
endmodule